// File: doc/BRIEF.md
# Code Address Patch Comparator

This block holds a bank of programmable comparators that watch the addresses of instruction fetches and literal loads in the code memory region, which spans 0x0000_0000 to 0x1FFF_FFFF. The first group of comparators watches only fetches. The second group watches only literal loads. When a fetch comparator matches, it either redirects the fetch into a patch area or raises a breakpoint request. When a literal comparator matches, it can only redirect the load. The block computes the redirected address and hands it to the memory system. It does not perform the redirection itself.

Software programs the block through a plain register port. The port has a write strobe, a 4-bit register address and 32-bit write data. Read data is combinational. The comparator encoding follows the `VERSION` parameter:

- **Version 1** stores a word address together with a half-word select.
- **Version 2** stores a half-word address. In version 2, a control bit chooses whether fetch comparators remap or break.

The parameter `REMAP_OK` sets whether redirection is supported at all.

Top module: `code_patch_cmp`

## Requirements
- R1: After reset, every comparator register, the global enable, the mode bit and the remap base read as zero, and all five outputs are low.
- R2: An address with any of bits [31:29] set never produces a remap or a breakpoint, whatever the comparator contents are.
- R3: A comparator responds only when control bit 0 (global enable) and bit 0 of its own register are both 1.
- R4: Comparators 0..NUM_INSN-1 respond only to the fetch port. Comparators NUM_INSN..NUM_INSN+NUM_LIT-1 respond only to the literal port.
- R5: A remap-mode comparator compares address bits [28:2] with its register bits [28:2]. On a match, the remapped address is the base plus 4 times the global comparator index plus the address bits [1:0].
- R6: In version 1, bits [31:30] of a fetch comparator select its action: 00 remaps, 01 breaks on the lower half-word (address bit 1 = 0), 10 breaks on the upper half-word, and 11 breaks on either half-word.
- R7: In version 2, control bit 1 set to 1 makes every fetch comparator a breakpoint that compares bits [31:1] of the register with the fetch address. With control bit 1 set to 0, fetch comparators remap as in R5. Version 1 ignores control bit 1.
- R8: A literal comparator never raises a breakpoint, and in version 1 its bits [31:30] have no effect.
- R9: The remap register reads the support flag at bit 29. When the flag is 0, no remap output ever goes high, but breakpoints still work.
- R10: When several comparators on one port match, the lowest-numbered one alone decides the result, even if it is a remap and a higher-numbered one is a breakpoint.
- R11: The outputs are registered. They reflect the address that was presented with its valid strobe at the previous clock edge, and they are low after any cycle without that strobe.
- R12: The register map is: address 0 is control (bit 0 global enable, bit 1 mode, bits [7:4] NUM_INSN, [11:8] NUM_LIT, [31:28] VERSION); address 1 is remap (base in bits [28:5]); address 2+i is comparator i. Other addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fetch_vld | input | 1 | Fetch address valid |
| fetch_addr | input | 32 | Instruction fetch address |
| lit_vld | input | 1 | Literal address valid |
| lit_addr | input | 32 | Literal load address |
| fetch_remap_vld | output | 1 | Fetch redirected |
| fetch_remap_addr | output | 32 | Redirect target for the fetch |
| lit_remap_vld | output | 1 | Literal load redirected |
| lit_remap_addr | output | 32 | Redirect target for the literal load |
| brk_req | output | 1 | Breakpoint request |

## Verification
The assertions check the following on every cycle:

- Outputs stay quiet after a cycle without a valid strobe.
- Addresses outside the code region never produce an output.
- A fetch never yields both a remap and a breakpoint.
- The remapped address keeps the byte offset of the request.
- Nothing is remapped when support is absent.
- A control write takes effect.

The choice of the comparator index, the half-word select encodings, version 2 half-word matching, priority between comparators and the value of the base-relative address can only be shown by the bench's scenarios. The bench checks these against a behavioural model of both versions on every clock.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
    localparam int REG_AW   = 4;
    localparam int ADDR_W   = 32;
    localparam int BASE_LSB = 5;
    localparam int BASE_W   = 29 - BASE_LSB;

    typedef struct packed {
        logic              brk;
        logic              frv;
        logic [ADDR_W-1:0] fra;
        logic              lrv;
        logic [ADDR_W-1:0] lra;
    } out_t;

    function automatic logic in_code(input logic [ADDR_W-1:0] a);
        return a[31:29] == 3'b000;
    endfunction
endpackage

// File: rtl/cpc_regfile.sv
module cpc_regfile
    import cpc_pkg::*;
#(
    parameter int NUM_INSN = 4,
    parameter int NUM_LIT  = 2,
    parameter int VERSION  = 1,
    parameter bit REMAP_OK = 1'b1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                reg_we,
    input  logic [REG_AW-1:0]                   reg_addr,
    input  logic [31:0]                         reg_wdata,
    output logic [31:0]                         reg_rdata,
    output logic                                glob_en,
    output logic                                brk_mode,
    output logic [BASE_W-1:0]                   remap_base,
    output logic [NUM_INSN+NUM_LIT-1:0][31:0]   comp_cfg
);
    localparam int NCMP = NUM_INSN + NUM_LIT;

    typedef struct packed {
        logic                  en;
        logic                  bm;
        logic [BASE_W-1:0]     base;
        logic [NCMP-1:0][31:0] cmp;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (reg_we) begin
            if (reg_addr == REG_AW'(0)) begin
                rf_d.en = reg_wdata[0];
                rf_d.bm = reg_wdata[1];
            end else if (reg_addr == REG_AW'(1)) begin
                rf_d.base = reg_wdata[28:BASE_LSB];
            end
            for (int i = 0; i < NCMP; i++) begin
                if (reg_addr == REG_AW'(i + 2)) rf_d.cmp[i] = reg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(0)) begin
            reg_rdata[0]     = rf_q.en;
            reg_rdata[1]     = rf_q.bm;
            reg_rdata[7:4]   = 4'(NUM_INSN);
            reg_rdata[11:8]  = 4'(NUM_LIT);
            reg_rdata[31:28] = 4'(VERSION);
        end else if (reg_addr == REG_AW'(1)) begin
            reg_rdata[29]          = REMAP_OK;
            reg_rdata[28:BASE_LSB] = rf_q.base;
        end
        for (int i = 0; i < NCMP; i++) begin
            if (reg_addr == REG_AW'(i + 2)) reg_rdata = rf_q.cmp[i];
        end
    end

    assign glob_en    = rf_q.en;
    assign brk_mode   = rf_q.bm;
    assign remap_base = rf_q.base;
    assign comp_cfg   = rf_q.cmp;

    // R3: a control write sets the global enable seen by the comparators
    a_r3_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == REG_AW'(0)) |=> (glob_en == $past(reg_wdata[0])));
endmodule

// File: rtl/cpc_unit.sv
module cpc_unit
    import cpc_pkg::*;
#(
    parameter int VERSION = 1,
    parameter bit IS_LIT  = 1'b0
) (
    input  logic              glob_en,
    input  logic              brk_mode,
    input  logic [31:0]       cfg,
    input  logic              vld,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              hit_brk
);
    logic active;
    logic word_eq;

    assign active  = glob_en && cfg[0] && vld && in_code(addr);
    assign word_eq = cfg[28:2] == addr[28:2];

    generate
        if (IS_LIT) begin : g_lit
            assign hit     = active && word_eq;
            assign hit_brk = 1'b0;
        end else if (VERSION == 1) begin : g_v1
            logic [1:0] sel;
            logic       half_ok;
            assign sel = cfg[31:30];
            always_comb begin
                case (sel)
                    2'b01:   half_ok = !addr[1];
                    2'b10:   half_ok = addr[1];
                    default: half_ok = 1'b1;
                endcase
            end
            assign hit     = active && word_eq && half_ok;
            assign hit_brk = sel != 2'b00;
        end else begin : g_v2
            logic half_eq;
            assign half_eq = cfg[31:1] == addr[31:1];
            assign hit     = active && (brk_mode ? half_eq : word_eq);
            assign hit_brk = brk_mode;
        end
    endgenerate
endmodule

// File: rtl/cpc_pick.sv
module cpc_pick
    import cpc_pkg::*;
#(
    parameter int NUM_INSN = 4,
    parameter int NUM_LIT  = 2,
    parameter bit REMAP_OK = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_INSN-1:0] f_hit,
    input  logic [NUM_INSN-1:0] f_brk,
    input  logic [NUM_LIT-1:0]  l_hit,
    input  logic                fetch_vld,
    input  logic [ADDR_W-1:0]   fetch_addr,
    input  logic                lit_vld,
    input  logic [ADDR_W-1:0]   lit_addr,
    input  logic [BASE_W-1:0]   remap_base,
    output out_t                res
);
    localparam int IDX_W = $clog2(NUM_INSN + NUM_LIT + 1);

    out_t             q_d, q_q;
    logic             f_any, f_isbrk, l_any;
    logic [IDX_W-1:0] f_idx, l_idx;
    logic [31:0]      base_addr;

    assign base_addr = {3'b000, remap_base, {BASE_LSB{1'b0}}};

    always_comb begin
        f_any   = 1'b0;
        f_isbrk = 1'b0;
        f_idx   = '0;
        for (int i = NUM_INSN - 1; i >= 0; i--) begin
            if (f_hit[i]) begin
                f_any   = 1'b1;
                f_isbrk = f_brk[i];
                f_idx   = IDX_W'(i);
            end
        end
        l_any = 1'b0;
        l_idx = '0;
        for (int j = NUM_LIT - 1; j >= 0; j--) begin
            if (l_hit[j]) begin
                l_any = 1'b1;
                l_idx = IDX_W'(NUM_INSN + j);
            end
        end
    end

    always_comb begin
        q_d     = '0;
        q_d.brk = f_any && f_isbrk;
        q_d.frv = f_any && !f_isbrk && REMAP_OK;
        q_d.fra = base_addr + {f_idx, 2'b00} + {30'd0, fetch_addr[1:0]};
        q_d.lrv = l_any && REMAP_OK;
        q_d.lra = base_addr + {l_idx, 2'b00} + {30'd0, lit_addr[1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign res = q_q;

    // R11: no fetch strobe, no fetch result next cycle
    a_r11_fetch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |=> (!q_q.brk && !q_q.frv));
    // R11: no literal strobe, no literal result next cycle
    a_r11_lit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lit_vld |=> !q_q.lrv);
    // R2: out-of-region fetch stays silent
    a_r2_fetch_region: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && fetch_addr[31:29] != 3'b000) |=> (!q_q.brk && !q_q.frv));
    // R2: out-of-region literal stays silent
    a_r2_lit_region: assert property (@(posedge clk) disable iff (!rst_n)
        (lit_vld && lit_addr[31:29] != 3'b000) |=> !q_q.lrv);
    // R5: remapped fetch keeps its byte offset
    a_r5_fetch_offset: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.frv |-> (q_q.fra[1:0] == $past(fetch_addr[1:0])));
    // R10: one winner decides the fetch, never both actions
    a_r10_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q_q.brk, q_q.frv}));

    generate
        if (!REMAP_OK) begin : g_norm
            // R9: without remap support nothing is redirected
            a_r9_no_remap: assert property (@(posedge clk) disable iff (!rst_n)
                !(q_q.frv || q_q.lrv));
        end
    endgenerate
endmodule

// File: rtl/code_patch_cmp.sv
module code_patch_cmp
    import cpc_pkg::*;
#(
    parameter int NUM_INSN = 4,
    parameter int NUM_LIT  = 2,
    parameter int VERSION  = 1,
    parameter bit REMAP_OK = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        fetch_vld,
    input  logic [31:0] fetch_addr,
    input  logic        lit_vld,
    input  logic [31:0] lit_addr,
    output logic        fetch_remap_vld,
    output logic [31:0] fetch_remap_addr,
    output logic        lit_remap_vld,
    output logic [31:0] lit_remap_addr,
    output logic        brk_req
);
    localparam int NCMP = NUM_INSN + NUM_LIT;

    logic                  glob_en, brk_mode;
    logic [BASE_W-1:0]     remap_base;
    logic [NCMP-1:0][31:0] comp_cfg;
    logic [NUM_INSN-1:0]   f_hit, f_brk;
    logic [NUM_LIT-1:0]    l_hit, l_brk_unused;
    out_t                  res;

    cpc_regfile #(
        .NUM_INSN(NUM_INSN), .NUM_LIT(NUM_LIT),
        .VERSION(VERSION), .REMAP_OK(REMAP_OK)
    ) u_rf (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glob_en(glob_en),
        .brk_mode(brk_mode), .remap_base(remap_base), .comp_cfg(comp_cfg)
    );

    generate
        for (genvar i = 0; i < NUM_INSN; i++) begin : g_insn
            cpc_unit #(.VERSION(VERSION), .IS_LIT(1'b0)) u_cmp (
                .glob_en(glob_en), .brk_mode(brk_mode), .cfg(comp_cfg[i]),
                .vld(fetch_vld), .addr(fetch_addr),
                .hit(f_hit[i]), .hit_brk(f_brk[i])
            );
        end
        for (genvar j = 0; j < NUM_LIT; j++) begin : g_lit
            cpc_unit #(.VERSION(VERSION), .IS_LIT(1'b1)) u_cmp (
                .glob_en(glob_en), .brk_mode(brk_mode), .cfg(comp_cfg[NUM_INSN+j]),
                .vld(lit_vld), .addr(lit_addr),
                .hit(l_hit[j]), .hit_brk(l_brk_unused[j])
            );
        end
    endgenerate

    cpc_pick #(.NUM_INSN(NUM_INSN), .NUM_LIT(NUM_LIT), .REMAP_OK(REMAP_OK)) u_pick (
        .clk(clk), .rst_n(rst_n), .f_hit(f_hit), .f_brk(f_brk), .l_hit(l_hit),
        .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
        .lit_vld(lit_vld), .lit_addr(lit_addr),
        .remap_base(remap_base), .res(res)
    );

    assign brk_req          = res.brk;
    assign fetch_remap_vld  = res.frv;
    assign fetch_remap_addr = res.fra;
    assign lit_remap_vld    = res.lrv;
    assign lit_remap_addr   = res.lra;

    // R8: literal comparators carry no breakpoint action
    a_r8_lit_no_brk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |=> !brk_req);
endmodule

// File: tb/code_patch_cmp_test.sv
module code_patch_cmp_test;
    localparam int NI = 4;
    localparam int NL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        fetch_vld = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        lit_vld = 1'b0;
    logic [31:0] lit_addr = '0;

    logic [31:0] rd1, fra1, lra1, rd2, fra2, lra2;
    logic        frv1, lrv1, brk1, frv2, lrv2, brk2;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    bit started = 1'b0;

    always #2.5 clk = ~clk;

    code_patch_cmp #(.NUM_INSN(NI), .NUM_LIT(NL), .VERSION(1), .REMAP_OK(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd1), .fetch_vld(fetch_vld),
        .fetch_addr(fetch_addr), .lit_vld(lit_vld), .lit_addr(lit_addr),
        .fetch_remap_vld(frv1), .fetch_remap_addr(fra1), .lit_remap_vld(lrv1),
        .lit_remap_addr(lra1), .brk_req(brk1)
    );

    code_patch_cmp #(.NUM_INSN(NI), .NUM_LIT(NL), .VERSION(2), .REMAP_OK(1'b0)) uut_v2 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd2), .fetch_vld(fetch_vld),
        .fetch_addr(fetch_addr), .lit_vld(lit_vld), .lit_addr(lit_addr),
        .fetch_remap_vld(frv2), .fetch_remap_addr(fra2), .lit_remap_vld(lrv2),
        .lit_remap_addr(lra2), .brk_req(brk2)
    );

    // behavioural reference state
    bit          m_en, m_bm;
    bit [31:0]   m_base;
    bit [31:0]   m_comp [NI+NL];
    bit          e1_brk, e1_frv, e1_lrv, e2_brk, e2_frv, e2_lrv;
    bit [31:0]   e1_fra, e1_lra, e2_fra, e2_lra;

    function automatic void model(input int ver, input bit rok,
                                  output bit brk, output bit frv, output bit [31:0] fra,
                                  output bit lrv, output bit [31:0] lra);
        brk = 0; frv = 0; fra = 0; lrv = 0; lra = 0;
        if (fetch_vld && m_en && fetch_addr < 32'h2000_0000) begin
            for (int i = 0; i < NI; i++) begin
                bit [31:0] c = m_comp[i];
                bit matched, is_brk;
                if (!c[0]) continue;
                if (ver == 1) begin
                    is_brk = c[31:30] != 0;
                    matched = (c[28:2] == fetch_addr[28:2]) &&
                              (c[31:30] != 2'd1 || fetch_addr[1] == 0) &&
                              (c[31:30] != 2'd2 || fetch_addr[1] == 1);
                end else if (m_bm) begin
                    is_brk = 1;
                    matched = (c >> 1) == (fetch_addr >> 1);
                end else begin
                    is_brk = 0;
                    matched = c[28:2] == fetch_addr[28:2];
                end
                if (matched) begin
                    if (is_brk) brk = 1;
                    else if (rok) begin
                        frv = 1;
                        fra = m_base + 4 * i + fetch_addr[1:0];
                    end
                    break;
                end
            end
        end
        if (lit_vld && m_en && lit_addr < 32'h2000_0000) begin
            for (int j = 0; j < NL; j++) begin
                bit [31:0] c = m_comp[NI+j];
                if (c[0] && c[28:2] == lit_addr[28:2]) begin
                    if (rok) begin
                        lrv = 1;
                        lra = m_base + 4 * (NI + j) + lit_addr[1:0];
                    end
                    break;
                end
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_bm = 0; m_base = 0;
            for (int k = 0; k < NI + NL; k++) m_comp[k] = 0;
            {e1_brk, e1_frv, e1_lrv, e2_brk, e2_frv, e2_lrv} = '0;
        end else begin
            model(1, 1'b1, e1_brk, e1_frv, e1_fra, e1_lrv, e1_lra);
            model(2, 1'b0, e2_brk, e2_frv, e2_fra, e2_lrv, e2_lra);
            if (reg_we) begin
                if (reg_addr == 0) begin m_en = reg_wdata[0]; m_bm = reg_wdata[1]; end
                else if (reg_addr == 1) m_base = reg_wdata & 32'h1FFF_FFE0;
                else if (reg_addr < 2 + NI + NL) m_comp[reg_addr-2] = reg_wdata;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // every-clock comparison against the model (R11 timing plus current scenario)
    always @(negedge clk) begin
        if (started) begin
            chk({cur_req, "/R11 v1 brk"}, brk1, e1_brk);
            chk({cur_req, "/R11 v1 frv"}, frv1, e1_frv);
            chk({cur_req, "/R11 v1 lrv"}, lrv1, e1_lrv);
            if (e1_frv) chk({cur_req, " v1 fra"}, fra1, e1_fra);
            if (e1_lrv) chk({cur_req, " v1 lra"}, lra1, e1_lra);
            chk({cur_req, "/R7 v2 brk"}, brk2, e2_brk);
            chk({cur_req, "/R9 v2 frv"}, frv2, e2_frv);
            chk({cur_req, "/R9 v2 lrv"}, lrv2, e2_lrv);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a,
                          input logic [31:0] exp1, input logic [31:0] exp2);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk({req, " read v1"}, rd1, exp1);
        chk({req, " read v2"}, rd2, exp2);
    endtask

    // one fetch strobe; result checked on uut one edge later
    task automatic fetch_chk(input string req, input logic [31:0] a,
                             input bit eb, input bit ev, input logic [31:0] ea);
        @(negedge clk);
        fetch_vld = 1; fetch_addr = a;
        @(negedge clk);
        fetch_vld = 0;
        chk({req, " brk"}, brk1, eb);
        chk({req, " remap vld"}, frv1, ev);
        if (ev) chk({req, " remap addr"}, fra1, ea);
    endtask

    task automatic lit_chk(input string req, input logic [31:0] a,
                           input bit ev, input logic [31:0] ea);
        @(negedge clk);
        lit_vld = 1; lit_addr = a;
        @(negedge clk);
        lit_vld = 0;
        chk({req, " lit vld"}, lrv1, ev);
        if (ev) chk({req, " lit addr"}, lra1, ea);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        started = 1;
        // R1, R12: reset values and register map
        cur_req = "R1";
        chk("R1 reset brk", brk1, 1'b0);
        chk("R1 reset frv", frv1, 1'b0);
        rd_chk("R12 ctrl", 4'd0, 32'h1000_0240, 32'h2000_0240);
        rd_chk("R9 remap flag", 4'd1, 32'h2000_0000, 32'h0000_0000);
        for (int k = 0; k < NI + NL; k++) rd_chk("R1 comp", 4'(k + 2), 32'h0, 32'h0);
        rd_chk("R12 unmapped", 4'd15, 32'h0, 32'h0);

        // R3: own enable set but global enable clear
        cur_req = "R3";
        wr(4'd1, 32'h0800_0000);
        rd_chk("R12 base", 4'd1, 32'h2800_0000, 32'h0800_0000);
        wr(4'd2, 32'h0000_1001);
        fetch_chk("R3 global off", 32'h0000_1000, 0, 0, 0);
        wr(4'd0, 32'h1);

        // R5: remap with byte offset
        cur_req = "R5";
        fetch_chk("R5 remap off2", 32'h0000_1002, 0, 1, 32'h0800_0002);
        fetch_chk("R5 remap off3", 32'h0000_1003, 0, 1, 32'h0800_0003);

        // R4: port separation
        cur_req = "R4";
        lit_chk("R4 lit vs insn comp", 32'h0000_1000, 0, 0);
        wr(4'd6, 32'hC000_4001);
        fetch_chk("R4 fetch vs lit comp", 32'h0000_4000, 0, 0, 0);

        // R8: literal select bits ignored
        cur_req = "R8";
        lit_chk("R8 lit remap", 32'h0000_4003, 1, 32'h0800_0013);

        // R6: version 1 half-word selects
        cur_req = "R6";
        wr(4'd3, 32'h4000_2001);
        fetch_chk("R6 lower hit", 32'h0000_2000, 1, 0, 0);
        fetch_chk("R6 lower miss", 32'h0000_2002, 0, 0, 0);
        wr(4'd4, 32'h8000_3001);
        fetch_chk("R6 upper hit", 32'h0000_3002, 1, 0, 0);
        fetch_chk("R6 upper miss", 32'h0000_3000, 0, 0, 0);
        wr(4'd5, 32'hC000_5001);
        fetch_chk("R6 both lo", 32'h0000_5000, 1, 0, 0);
        fetch_chk("R6 both hi", 32'h0000_5002, 1, 0, 0);

        // R2: outside code region
        cur_req = "R2";
        fetch_chk("R2 fetch high", 32'h2000_1000, 0, 0, 0);
        lit_chk("R2 lit high", 32'hE000_4000, 0, 0);

        // R10: priority
        cur_req = "R10";
        wr(4'd3, 32'h4000_1001);
        fetch_chk("R10 remap beats brk", 32'h0000_1000, 0, 1, 32'h0800_0000);
        wr(4'd2, 32'h0000_1000);
        fetch_chk("R10 R3 own off", 32'h0000_1000, 1, 0, 0);
        wr(4'd7, 32'h0000_4001);
        lit_chk("R10 lit lowest", 32'h0000_4000, 1, 32'h0800_0010);

        // R11: both ports at once
        cur_req = "R11";
        @(negedge clk);
        fetch_vld = 1; fetch_addr = 32'h0000_1000; lit_vld = 1; lit_addr = 32'h0000_4002;
        @(negedge clk);
        fetch_vld = 0; lit_vld = 0;
        chk("R11 dual brk", brk1, 1'b1);
        chk("R11 dual lit", lra1, 32'h0800_0012);
        @(negedge clk);
        chk("R11 pulse ends", {brk1, lrv1}, 2'b00);

        // R7: version 2 half-word breakpoints, version 1 ignores the mode bit
        cur_req = "R7";
        wr(4'd0, 32'h3);
        wr(4'd3, 32'h0000_2003);
        fetch_chk("R7 v1 ignores mode", 32'h0000_2002, 0, 1, 32'h0800_0006);
        chk("R7 v2 half hit", brk2, 1'b1);
        fetch_chk("R7 v1 word", 32'h0000_2000, 0, 1, 32'h0800_0004);
        chk("R7 v2 half miss", brk2, 1'b0);

        // R9: version 2 without remap support
        cur_req = "R9";
        wr(4'd0, 32'h1);
        lit_chk("R9 v1 lit", 32'h0000_4001, 1, 32'h0800_0011);
        chk("R9 v2 no lit remap", lrv2, 1'b0);
        fetch_chk("R9 v1 fetch", 32'h0000_2001, 0, 1, 32'h0800_0005);
        chk("R9 v2 no fetch remap", frv2, 1'b0);

        repeat (3) @(negedge clk);
        started = 0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule